// File: doc/BRIEF.md
# Signed-Magnitude Add/Subtract Unit

This unit adds or subtracts two numbers kept in sign-plus-magnitude form. Each operand is one sign bit and a `WIDTH`-bit magnitude. A caller presents both operands and an operation select, then pulses `start`. The unit captures everything on that edge. It decides from the two signs and the requested operation whether the magnitudes must be summed or differenced, and it works the result out over a few clock cycles. It raises `done` for exactly one cycle when the sign, magnitude and overflow outputs are valid.

When magnitudes are summed, a carry out of the top bit is reported as an add overflow, and the magnitude output keeps the low bits. When magnitudes are differenced, the first magnitude is added to the two's complement of the second. If that subtraction produced no carry, the second magnitude was larger. The unit then takes the two's complement of the partial result, in two extra cycles, and flips the sign. A zero produced by a subtraction is always reported as positive. The outputs hold their values from `done` until the next accepted `start`.

Top module: `sm_addsub`

## Requirements
- R1: The magnitudes are summed when `op_sub`=0 and the two signs are equal, or when `op_sub`=1 and the signs differ. In that case `res_mag` is (A+B) mod 2^WIDTH and `res_sign` equals `a_sign`.
- R2: On a summing path, `add_ovf` is 1 exactly when A+B ≥ 2^WIDTH. On every differencing path, `add_ovf` is 0.
- R3: On a differencing path with A ≥ B, `res_mag` is A−B and `res_sign` is `a_sign`, except as R5 states.
- R4: On a differencing path with A < B, `res_mag` is B−A and `res_sign` is the inverse of `a_sign`.
- R5: A differencing path whose result is zero yields `res_sign`=0 (positive zero), whatever the operand signs.
- R6: `done` is high for exactly one cycle. Counting the edge that samples `start` as edge 1, `done` is first seen high after edge 2 when no correction is needed, and after edge 4 on the R4 path.
- R7: A `start` that arrives while an operation is in progress is ignored. It produces no extra `done`, and it does not alter the result of the running operation. The outputs then stay unchanged until the next accepted `start`.
- R8: After synchronous reset, `done`, `res_sign`, `res_mag` and `add_ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; operands sampled on this edge when idle |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| a_sign | input | 1 | Sign of first operand (1 = negative) |
| a_mag | input | WIDTH | Magnitude of first operand |
| b_sign | input | 1 | Sign of second operand (1 = negative) |
| b_mag | input | WIDTH | Magnitude of second operand |
| done | output | 1 | One-cycle pulse: result valid |
| res_sign | output | 1 | Sign of result |
| res_mag | output | WIDTH | Magnitude of result |
| add_ovf | output | 1 | Magnitude sum overflowed |

## Verification
Operands are chosen so that every pairing of the two signs with the two operations is exercised. Each pairing is tried with a larger first magnitude, a larger second magnitude and equal magnitudes. These cases separate the summing paths from the differencing paths, and the plain differencing path from the corrected one. The corrected path is also distinguished by its four-edge latency. Sums above 2^WIDTH−1 are used to show that overflow appears only on summing paths. The equal-magnitude cases (5−5, −5+5, −5−(−5)) single out the positive-zero rule. A burst of `start` pulses with different operands, sent during a corrected operation, shows whether those requests are dropped or allowed to leak into the result.

// File: rtl/sm_pkg.sv
package sm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARITH = 2'd1,
        ST_CORR  = 2'd2,
        ST_DONE  = 2'd3
    } sm_state_e;

    // One-hot step commands from controller to datapath
    typedef struct packed {
        logic load;   // capture operands
        logic arith;  // sum or difference of magnitudes
        logic comp;   // ones' complement of partial result
        logic inc;    // increment partial result
    } sm_cmd_t;

    // Magnitudes are summed when the sign relation matches the op
    function automatic logic eff_is_add(input logic op_sub,
                                        input logic sa,
                                        input logic sb);
        return ((sa ^ sb) == op_sub);
    endfunction

endpackage

// File: rtl/sm_ctrl.sv
module sm_ctrl
    import sm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    need_corr,
    output sm_cmd_t cmd,
    output logic    busy,
    output logic    done
);

    sm_state_e state_q, state_d;
    logic      phase_q, phase_d;

    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        cmd     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cmd.load = 1'b1;
                    state_d  = ST_ARITH;
                end
            end
            ST_ARITH: begin
                cmd.arith = 1'b1;
                phase_d   = 1'b0;
                state_d   = need_corr ? ST_CORR : ST_DONE;
            end
            ST_CORR: begin
                if (!phase_q) begin
                    cmd.comp = 1'b1;
                    phase_d  = 1'b1;
                end else begin
                    cmd.inc  = 1'b1;
                    state_d  = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_DONE);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (state_q == ST_ARITH));

    // R6
    corr_two_step_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.comp |=> cmd.inc);

endmodule

// File: rtl/sm_datapath.sv
module sm_datapath
    import sm_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  sm_cmd_t          cmd,
    input  logic             busy,
    input  logic             start,
    input  logic             done,
    input  logic             op_sub,
    input  logic             a_sign,
    input  logic [WIDTH-1:0] a_mag,
    input  logic             b_sign,
    input  logic [WIDTH-1:0] b_mag,
    output logic             need_corr,
    output logic             res_sign,
    output logic [WIDTH-1:0] res_mag,
    output logic             add_ovf
);

    localparam int SUMW = WIDTH + 1;

    logic             as_q;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic             eff_add_q;
    logic             avf_q;

    logic [SUMW-1:0]  sum;
    logic             carry;
    logic [WIDTH-1:0] sum_lo;

    // Sum path: A + B. Difference path: A + ~B + 1.
    always_comb begin
        sum    = {1'b0, a_q}
               + {1'b0, (eff_add_q ? b_q : ~b_q)}
               + {{WIDTH{1'b0}}, ~eff_add_q};
        carry  = sum[SUMW-1];
        sum_lo = sum[WIDTH-1:0];
    end

    assign need_corr = !eff_add_q && !carry;

    always_ff @(posedge clk) begin
        if (rst) begin
            as_q      <= 1'b0;
            a_q       <= '0;
            b_q       <= '0;
            eff_add_q <= 1'b0;
            avf_q     <= 1'b0;
        end else begin
            if (cmd.load) begin
                as_q      <= a_sign;
                a_q       <= a_mag;
                b_q       <= b_mag;
                eff_add_q <= eff_is_add(op_sub, a_sign, b_sign);
            end
            if (cmd.arith) begin
                a_q   <= sum_lo;
                avf_q <= eff_add_q ? carry : 1'b0;
                if (!eff_add_q) begin
                    if (!carry)
                        as_q <= ~as_q;
                    else if (sum_lo == '0)
                        as_q <= 1'b0;
                end
            end
            if (cmd.comp)
                a_q <= ~a_q;
            if (cmd.inc)
                a_q <= a_q + 1'b1;
        end
    end

    assign res_sign = as_q;
    assign res_mag  = a_q;
    assign add_ovf  = avf_q;

    // R5
    pos_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !eff_add_q && (a_q == '0)) |-> !as_q);

    // R2
    no_diff_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !eff_add_q) |-> !avf_q);

    // R7
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(b_q) && $stable(eff_add_q)));

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(a_q) && $stable(as_q) && $stable(avf_q)));

endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
    import sm_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             op_sub,
    input  logic             a_sign,
    input  logic [WIDTH-1:0] a_mag,
    input  logic             b_sign,
    input  logic [WIDTH-1:0] b_mag,
    output logic             done,
    output logic             res_sign,
    output logic [WIDTH-1:0] res_mag,
    output logic             add_ovf
);

    sm_cmd_t cmd;
    logic    busy;
    logic    need_corr;

    sm_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .need_corr (need_corr),
        .cmd       (cmd),
        .busy      (busy),
        .done      (done)
    );

    sm_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .busy      (busy),
        .start     (start),
        .done      (done),
        .op_sub    (op_sub),
        .a_sign    (a_sign),
        .a_mag     (a_mag),
        .b_sign    (b_sign),
        .b_mag     (b_mag),
        .need_corr (need_corr),
        .res_sign  (res_sign),
        .res_mag   (res_mag),
        .add_ovf   (add_ovf)
    );

endmodule

// File: tb/tb_sm_addsub.sv
module tb_sm_addsub;

    localparam int W = 8;
    localparam int MODV = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         op_sub = 1'b0;
    logic         a_sign = 1'b0;
    logic [W-1:0] a_mag = '0;
    logic         b_sign = 1'b0;
    logic [W-1:0] b_mag = '0;
    logic         done;
    logic         res_sign;
    logic [W-1:0] res_mag;
    logic         add_ovf;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;  // 50 MHz

    sm_addsub #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .start(start), .op_sub(op_sub),
        .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
        .done(done), .res_sign(res_sign), .res_mag(res_mag), .add_ovf(add_ovf)
    );

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual cycles=%0d expected <100000", cyc);
            summary_and_end();
        end
    end

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected results derived from R1..R5 and R6 latency
    task automatic model(input bit op, input bit as, input int am,
                         input bit bs, input int bm,
                         output bit es, output int em, output bit eo,
                         output int elat);
        bit add_path;
        add_path = ((as ^ bs) == op);
        elat = 2;
        if (add_path) begin
            em = (am + bm) % MODV;
            eo = (am + bm) >= MODV;
            es = as;
        end else begin
            eo = 1'b0;
            if (am >= bm) begin
                em = am - bm;
                es = (am == bm) ? 1'b0 : as;
            end else begin
                em = bm - am;
                es = ~as;
                elat = 4;
            end
        end
    endtask

    task automatic run_op(input string req, input bit op, input bit as,
                          input int am, input bit bs, input int bm);
        bit es, eo;
        int em, elat, lat;
        model(op, as, am, bs, bm, es, em, eo, elat);
        @(negedge clk);
        op_sub = op; a_sign = as; a_mag = am[W-1:0];
        b_sign = bs; b_mag = bm[W-1:0]; start = 1'b1;
        @(posedge clk); lat = 1;
        @(negedge clk); start = 1'b0;
        while (!done && lat < 20) begin
            @(posedge clk); lat++;
            @(negedge clk);
        end
        check(req, "sign", res_sign, es);
        check(req, "mag", res_mag, em);
        check(req, "ovf", add_ovf, eo);
        check("R6", "latency", lat, elat);
        @(posedge clk); @(negedge clk);
        check("R6", "done width", done, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R8", "done", done, 0);
        check("R8", "sign", res_sign, 0);
        check("R8", "mag", res_mag, 0);
        check("R8", "ovf", add_ovf, 0);
    endtask

    task automatic t_sum_paths();
        run_op("R1", 1'b0, 1'b0, 20, 1'b0, 35);
        run_op("R1", 1'b0, 1'b1, 20, 1'b1, 35);
        run_op("R1", 1'b1, 1'b0, 20, 1'b1, 35);
        run_op("R1", 1'b1, 1'b1, 0, 1'b0, 9);
    endtask

    task automatic t_overflow();
        run_op("R2", 1'b0, 1'b0, 200, 1'b0, 100);
        run_op("R2", 1'b1, 1'b1, 200, 1'b0, 100);
        run_op("R2", 1'b0, 1'b0, 255, 1'b0, 1);
        run_op("R2", 1'b0, 1'b0, 255, 1'b0, 0);
    endtask

    task automatic t_diff_ge();
        run_op("R3", 1'b1, 1'b0, 50, 1'b0, 20);
        run_op("R3", 1'b0, 1'b1, 50, 1'b0, 20);
        run_op("R3", 1'b1, 1'b0, 255, 1'b0, 0);
    endtask

    task automatic t_diff_lt();
        run_op("R4", 1'b1, 1'b0, 20, 1'b0, 50);
        run_op("R4", 1'b1, 1'b1, 20, 1'b1, 50);
        run_op("R4", 1'b1, 1'b0, 0, 1'b0, 1);
        run_op("R4", 1'b0, 1'b0, 0, 1'b1, 255);
    endtask

    task automatic t_pos_zero();
        run_op("R5", 1'b1, 1'b0, 5, 1'b0, 5);
        run_op("R5", 1'b0, 1'b1, 5, 1'b0, 5);
        run_op("R5", 1'b1, 1'b1, 5, 1'b1, 5);
        run_op("R5", 1'b0, 1'b0, 0, 1'b1, 0);
    endtask

    // R7: extra starts during a corrected operation are dropped
    task automatic t_busy_start();
        int lat;
        int dones;
        @(negedge clk);
        op_sub = 1'b1; a_sign = 1'b0; a_mag = 8'd20;
        b_sign = 1'b0; b_mag = 8'd50; start = 1'b1;
        @(posedge clk); lat = 1;
        @(negedge clk);
        op_sub = 1'b0; a_mag = 8'd1; b_mag = 8'd1;
        while (!done && lat < 20) begin
            @(posedge clk); lat++;
            @(negedge clk);
        end
        start = 1'b0;
        check("R7", "sign", res_sign, 1);
        check("R7", "mag", res_mag, 30);
        check("R7", "latency", lat, 4);
        dones = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); @(negedge clk);
            if (done) dones++;
        end
        check("R7", "extra done", dones, 0);
        check("R7", "held mag", res_mag, 30);
        check("R7", "held sign", res_sign, 1);
    endtask

    task automatic t_sweep();
        int pairs[6] = '{7, 3, 3, 7, 128, 128};
        for (int k = 0; k < 8; k++) begin
            for (int p = 0; p < 3; p++) begin
                run_op("R1", k[2], k[1], pairs[2*p], k[0], pairs[2*p+1]);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_sum_paths();
        t_overflow();
        t_diff_ge();
        t_diff_lt();
        t_pos_zero();
        t_busy_start();
        t_sweep();
        summary_and_end();
    end

endmodule